// File: doc/BRIEF.md
# SDRAM Write-Burst Termination Sequencer

This block sits inside an SDRAM controller. It cuts short a write burst that is already running. The controller presents a termination request on the cycle whose closing clock edge registers the last write data beat it wants kept. The request names either a READ or a PRECHARGE, together with a bank, a column and a few qualifiers. The block then drives the command bus, bank, address and the data mask, each from a register, so that the terminating command reaches the device at the correct edge.

A READ termination goes out on the cycle right after acceptance. The device drops any write data that follows it. A PRECHARGE termination is placed after the write-recovery time. That time is one clock when the configured clock period is at least `TWR_NS` nanoseconds, and two clocks when the period is shorter. Unless the burst is a fixed length of two, the data mask is raised on the edge before the PRECHARGE and on the PRECHARGE edge itself. After a PRECHARGE, a per-bank timer refuses further requests to that bank for `TRP_CYC` clocks. A one-cycle done pulse marks the point at which the bank is usable again.

The command bus uses the encoding {cs_n, ras_n, cas_n, we_n}: NOP=0111, READ=0101, PRECHARGE=0010. Address bit `AP_BIT` (bit 10) set on a PRECHARGE selects all banks.

Top module: `sdram_wterm_top`

## Requirements
- R1: After reset, cmd_o is NOP (0111), dqm_o is 0, done_o is all zero, and req_ready_o is 1 for a READ request to any bank.
- R2: An accepted READ request (req_kind_i=0) puts READ (0101) on cmd_o in the next cycle. In that cycle bank_o is the requested bank, addr_o is the column with bit 10 low, and dqm_o is 0. The cycle after it returns to NOP.
- R3: An accepted PRECHARGE request (req_kind_i=1) with tclk_ns_i >= 15 puts PRECHARGE (0010) on cmd_o in the next cycle. dqm_o is 1 in that cycle unless req_bl2_i is set.
- R4: An accepted PRECHARGE request with tclk_ns_i < 15 puts NOP with dqm_o=1 on cmd_o in the next cycle, then PRECHARGE with dqm_o=1 in the cycle after.
- R5: When req_bl2_i is set on a PRECHARGE request, dqm_o stays 0 through the whole sequence in both clock-period cases.
- R6: With req_all_i=1, the PRECHARGE has addr_o bit 10 set and all other address bits 0. Such a request is refused while any bank is in its precharge interval.
- R7: A PRECHARGE request with req_ap_i=1 (the burst already uses auto precharge) is refused and issues nothing. A READ request with req_ap_i=1 is accepted.
- R8: Requests to a bank are refused for TRP_CYC cycles, counting from the cycle in which its PRECHARGE is on cmd_o.
- R9: done_o[b] is high for exactly one cycle: the first cycle in which bank b accepts requests again after a PRECHARGE.
- R10: req_ready_o is 0 during the extra write-recovery cycle of R4. While one bank is in its precharge interval, requests to other banks are still accepted.
- R11: Outside the cycles named in R2 to R4, cmd_o is NOP with dqm_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Termination request valid |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_kind_i | input | 1 | 0 = terminate with READ, 1 = terminate with PRECHARGE |
| req_bank_i | input | BANK_W (2) | Target bank |
| req_col_i | input | COL_W (9) | READ column |
| req_all_i | input | 1 | PRECHARGE all banks |
| req_ap_i | input | 1 | Burst being cut was issued with auto precharge |
| req_bl2_i | input | 1 | Burst is a fixed length of two and completes; no masking |
| tclk_ns_i | input | 8 | Clock period in ns |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| bank_o | output | BANK_W (2) | Command bank |
| addr_o | output | ADDR_W (13) | Command address |
| dqm_o | output | 1 | Write data mask |
| done_o | output | NB (4) | Per-bank pulse: bank usable again |

## Verification
The hardest case to reach from the ports is a bank that is partway through its precharge interval while other requests arrive. Some of those requests target the same bank, some target a free bank, and some ask to precharge all banks. The bench issues a PRECHARGE and then, in each interval cycle, re-aims the request fields at each of these targets and reads req_ready_o. It then samples done_o in the exact cycle the interval closes. A second directed case probes readiness in the extra recovery cycle of the short-period path. The vector table covers tclk_ns_i at 15 and at 14, which sit on either side of the recovery threshold.

// File: rtl/sdram_wterm_pkg.sv
package sdram_wterm_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011
  } cmd_e;

  typedef enum logic {
    TERM_READ = 1'b0,
    TERM_PRE  = 1'b1
  } term_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_GAP  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sdram_wterm_timer.sv
module sdram_wterm_timer #(
  parameter int NB      = 4,
  parameter int TRP_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] load_i,
  output logic [NB-1:0] busy_o,
  output logic [NB-1:0] done_o
);
  localparam int CW = $clog2(TRP_CYC + 1);
  localparam logic [CW-1:0] LOADV = CW'(TRP_CYC);
  localparam logic [CW-1:0] ONE   = CW'(1);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else begin
        done_q <= (cnt_q == ONE);
        if (load_i[b])          cnt_q <= LOADV;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
      end
    end

    assign busy_o[b] = (cnt_q != '0);
    assign done_o[b] = done_q;
  end
endmodule

// File: rtl/sdram_wterm_admit.sv
module sdram_wterm_admit #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int TWR_NS = 15
) (
  input  logic              idle_i,
  input  logic [NB-1:0]     busy_i,
  input  logic              kind_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              all_i,
  input  logic              ap_i,
  input  logic [7:0]        tclk_ns_i,
  output logic              ready_o,
  output logic              slow_o
);
  import sdram_wterm_pkg::*;

  logic is_pre;
  logic conflict;

  assign is_pre = (kind_i == TERM_PRE);
  assign slow_o = (tclk_ns_i >= 8'(TWR_NS));

  always_comb begin
    if (is_pre && all_i) conflict = |busy_i;
    else                 conflict = busy_i[bank_i];
  end

  // precharge is not legal when the burst already auto-precharges
  assign ready_o = idle_i && !conflict && !(is_pre && ap_i);
endmodule

// File: rtl/sdram_wterm_seq.sv
module sdram_wterm_seq #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              kind_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              all_i,
  input  logic              bl2_i,
  input  logic              slow_i,
  output logic              idle_o,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic [NB-1:0]     load_o
);
  import sdram_wterm_pkg::*;

  seq_state_e        st_q;
  logic [BANK_W-1:0] h_bank_q;
  logic              h_all_q;
  logic              h_mask_q;
  logic              pre_fire;
  logic [BANK_W-1:0] pre_bank;
  logic              pre_all;

  function automatic logic [ADDR_W-1:0] pre_addr(input logic all);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[AP_BIT] = all;
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] rd_addr(input logic [COL_W-1:0] c);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(c);
    a[AP_BIT] = 1'b0;
    return a;
  endfunction

  assign idle_o = (st_q == ST_IDLE);

  always_comb begin
    pre_fire = 1'b0;
    pre_bank = bank_i;
    pre_all  = all_i;
    if (st_q == ST_GAP) begin
      pre_fire = 1'b1;
      pre_bank = h_bank_q;
      pre_all  = h_all_q;
    end else if (accept_i && kind_i == TERM_PRE && slow_i) begin
      pre_fire = 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_load
    assign load_o[b] = pre_fire && (pre_all || pre_bank == BANK_W'(b));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cmd_o    <= CMD_NOP;
      bank_o   <= '0;
      addr_o   <= '0;
      dqm_o    <= 1'b0;
      h_bank_q <= '0;
      h_all_q  <= 1'b0;
      h_mask_q <= 1'b0;
    end else begin
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      dqm_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_i) begin
            bank_o <= bank_i;
            if (kind_i == TERM_READ) begin
              cmd_o  <= CMD_READ;
              addr_o <= rd_addr(col_i);
            end else if (slow_i) begin
              cmd_o  <= CMD_PRE;
              addr_o <= pre_addr(all_i);
              dqm_o  <= !bl2_i;
            end else begin
              // extra recovery clock, mask held over it
              dqm_o    <= !bl2_i;
              h_bank_q <= bank_i;
              h_all_q  <= all_i;
              h_mask_q <= !bl2_i;
              st_q     <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          cmd_o  <= CMD_PRE;
          bank_o <= h_bank_q;
          addr_o <= pre_addr(h_all_q);
          dqm_o  <= h_mask_q;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_wterm_top.sv
module sdram_wterm_top #(
  parameter int NB      = 4,
  parameter int BANK_W  = $clog2(NB),
  parameter int COL_W   = 9,
  parameter int ADDR_W  = 13,
  parameter int AP_BIT  = 10,
  parameter int TWR_NS  = 15,
  parameter int TRP_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_kind_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_all_i,
  input  logic              req_ap_i,
  input  logic              req_bl2_i,
  input  logic [7:0]        tclk_ns_i,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic [NB-1:0]     done_o
);
  logic          idle;
  logic          slow;
  logic          accept;
  logic [NB-1:0] busy;
  logic [NB-1:0] load;

  assign accept = req_valid_i && req_ready_o;

  sdram_wterm_admit #(
    .NB(NB), .BANK_W(BANK_W), .TWR_NS(TWR_NS)
  ) u_admit (
    .idle_i   (idle),
    .busy_i   (busy),
    .kind_i   (req_kind_i),
    .bank_i   (req_bank_i),
    .all_i    (req_all_i),
    .ap_i     (req_ap_i),
    .tclk_ns_i(tclk_ns_i),
    .ready_o  (req_ready_o),
    .slow_o   (slow)
  );

  sdram_wterm_seq #(
    .NB(NB), .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .kind_i  (req_kind_i),
    .bank_i  (req_bank_i),
    .col_i   (req_col_i),
    .all_i   (req_all_i),
    .bl2_i   (req_bl2_i),
    .slow_i  (slow),
    .idle_o  (idle),
    .cmd_o   (cmd_o),
    .bank_o  (bank_o),
    .addr_o  (addr_o),
    .dqm_o   (dqm_o),
    .load_o  (load)
  );

  sdram_wterm_timer #(
    .NB(NB), .TRP_CYC(TRP_CYC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .busy_o(busy),
    .done_o(done_o)
  );
endmodule

// File: rtl/sdram_wterm_chk.sv
module sdram_wterm_chk #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int TWR_NS = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_kind_i,
  input logic              req_ap_i,
  input logic [7:0]        tclk_ns_i,
  input logic [3:0]        cmd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dqm_o,
  input logic [NB-1:0]     done_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  AST_READ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !req_kind_i |=> cmd_o == 4'b0101 && !dqm_o); // R2
  AST_READ_A10_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 4'b0101 |-> !addr_o[AP_BIT]); // R2
  AST_SLOW_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_kind_i && tclk_ns_i >= 8'(TWR_NS) |=> cmd_o == 4'b0010); // R3
  AST_FAST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_kind_i && tclk_ns_i < 8'(TWR_NS) |=> cmd_o == 4'b0111 && !req_ready_o); // R4
  AST_MASKED_GAP_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 4'b0111 && dqm_o |=> cmd_o == 4'b0010 && dqm_o); // R4
  AST_AP_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_kind_i && req_ap_i |-> !req_ready_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> (done_o & $past(done_o)) == '0); // R9
endmodule

bind sdram_wterm_top sdram_wterm_chk #(
  .NB(NB), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .TWR_NS(TWR_NS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_kind_i (req_kind_i),
  .req_ap_i   (req_ap_i),
  .tclk_ns_i  (tclk_ns_i),
  .cmd_o      (cmd_o),
  .addr_o     (addr_o),
  .dqm_o      (dqm_o),
  .done_o     (done_o)
);

// File: tb/sdram_wterm_top_bench.sv
`timescale 1ns/1ps
module sdram_wterm_top_bench;
  localparam int TRP = 3;
  localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, PRE = 4'b0010;

  typedef struct packed {
    logic        kind;
    logic [1:0]  bank;
    logic [8:0]  col;
    logic        all;
    logic        ap;
    logic        bl2;
    logic [7:0]  tclk;
    logic        acc;
    logic [3:0]  c1cmd;
    logic        c1dqm;
    logic [3:0]  c2cmd;
    logic        c2dqm;
    logic [12:0] addr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 9'h005, 1'b0, 1'b0, 1'b0, 8'd20, 1'b1, RD,  1'b0, NOP, 1'b0, 13'h0005, 4'd2}, // R2
    '{1'b0, 2'd3, 9'h1FF, 1'b0, 1'b0, 1'b0, 8'd10, 1'b1, RD,  1'b0, NOP, 1'b0, 13'h01FF, 4'd2}, // R2
    '{1'b1, 2'd1, 9'h000, 1'b0, 1'b0, 1'b0, 8'd20, 1'b1, PRE, 1'b1, NOP, 1'b0, 13'h0000, 4'd3}, // R3
    '{1'b1, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 8'd10, 1'b1, NOP, 1'b1, PRE, 1'b1, 13'h0000, 4'd4}, // R4
    '{1'b1, 2'd0, 9'h000, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, NOP, 1'b0, PRE, 1'b0, 13'h0000, 4'd5}, // R5
    '{1'b1, 2'd3, 9'h000, 1'b0, 1'b0, 1'b1, 8'd20, 1'b1, PRE, 1'b0, NOP, 1'b0, 13'h0000, 4'd5}, // R5
    '{1'b1, 2'd0, 9'h000, 1'b1, 1'b0, 1'b0, 8'd20, 1'b1, PRE, 1'b1, NOP, 1'b0, 13'h0400, 4'd6}, // R6
    '{1'b1, 2'd1, 9'h000, 1'b0, 1'b1, 1'b0, 8'd20, 1'b0, NOP, 1'b0, NOP, 1'b0, 13'h0000, 4'd7}, // R7
    '{1'b0, 2'd2, 9'h0AA, 1'b0, 1'b1, 1'b0, 8'd20, 1'b1, RD,  1'b0, NOP, 1'b0, 13'h00AA, 4'd7}, // R7
    '{1'b1, 2'd1, 9'h000, 1'b1, 1'b0, 1'b0, 8'd10, 1'b1, NOP, 1'b1, PRE, 1'b1, 13'h0400, 4'd6}, // R6
    '{1'b1, 2'd0, 9'h000, 1'b0, 1'b0, 1'b0, 8'd15, 1'b1, PRE, 1'b1, NOP, 1'b0, 13'h0000, 4'd3}, // R3
    '{1'b1, 2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 8'd14, 1'b1, NOP, 1'b1, PRE, 1'b1, 13'h0000, 4'd4}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, kind = 1'b0, all = 1'b0, ap = 1'b0, bl2 = 1'b0;
  logic [1:0]  bank = '0;
  logic [8:0]  col = '0;
  logic [7:0]  tclk = 8'd20;
  logic        ready, dqm;
  logic [3:0]  cmd, done;
  logic [1:0]  bank_q;
  logic [12:0] addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sdram_wterm_top #(.TRP_CYC(TRP)) u_sdram_wterm_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_kind_i(kind), .req_bank_i(bank), .req_col_i(col), .req_all_i(all),
    .req_ap_i(ap), .req_bl2_i(bl2), .tclk_ns_i(tclk), .cmd_o(cmd),
    .bank_o(bank_q), .addr_o(addr), .dqm_o(dqm), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string rtag(input logic [3:0] n);
    return $sformatf("R%0d", n);
  endfunction

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    kind = v.kind; bank = v.bank; col = v.col; all = v.all;
    ap = v.ap; bl2 = v.bl2; tclk = v.tclk; valid = 1'b1;
    #1 check({rtag(v.req), " ready"}, 32'(ready), 32'(v.acc));
    @(negedge clk);
    valid = 1'b0;
    check({rtag(v.req), " cmd1"}, 32'(cmd), 32'(v.c1cmd));
    check({rtag(v.req), " dqm1"}, 32'(dqm), 32'(v.c1dqm));
    if (v.c1cmd != NOP) begin
      check({rtag(v.req), " addr1"}, 32'(addr), 32'(v.addr));
      check({rtag(v.req), " bank1"}, 32'(bank_q), 32'(v.bank));
    end
    @(negedge clk);
    check({rtag(v.req), " cmd2"}, 32'(cmd), 32'(v.c2cmd));
    check({rtag(v.req), " dqm2"}, 32'(dqm), 32'(v.c2dqm));
    if (v.c2cmd != NOP) begin
      check({rtag(v.req), " addr2"}, 32'(addr), 32'(v.addr));
      check({rtag(v.req), " bank2"}, 32'(bank_q), 32'(v.bank));
    end
    // R11: quiet bus afterwards
    @(negedge clk);
    check("R11 idle cmd", 32'(cmd), 32'(NOP));
    check("R11 idle dqm", 32'(dqm), 32'd0);
    repeat (TRP + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cmd", 32'(cmd), 32'(NOP));
    check("R1 dqm", 32'(dqm), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 ready", 32'(ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8 / R9 / R10 / R6: probe readiness through the precharge interval
    @(negedge clk);
    kind = 1'b1; bank = 2'd1; all = 1'b0; ap = 1'b0; bl2 = 1'b0; tclk = 8'd20; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R3 pre on bus", 32'(cmd), 32'(PRE));
    for (int i = 0; i < TRP; i++) begin
      kind = 1'b0; bank = 2'd1; all = 1'b0;
      #1 check("R8 busy bank refused", 32'(ready), 32'd0);
      check("R9 no early done", 32'(done), 32'd0);
      bank = 2'd2;
      #1 check("R10 other bank free", 32'(ready), 32'd1);
      kind = 1'b1; all = 1'b1;
      #1 check("R6 all refused while busy", 32'(ready), 32'd0);
      all = 1'b0; kind = 1'b0; bank = 2'd1;
      @(negedge clk);
    end
    #1 check("R8 bank free again", 32'(ready), 32'd1);
    check("R9 done pulse", 32'(done), 32'b0010);
    @(negedge clk);
    check("R9 done one cycle", 32'(done), 32'd0);
    repeat (2) @(negedge clk);

    // R10: refused during extra recovery cycle
    kind = 1'b1; bank = 2'd0; tclk = 8'd10; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; kind = 1'b0; bank = 2'd3;
    #1 check("R10 gap refused", 32'(ready), 32'd0);
    check("R4 gap nop", 32'(cmd), 32'(NOP));
    @(negedge clk);
    check("R4 gap pre", 32'(cmd), 32'(PRE));
    repeat (TRP + 2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule